// File: doc/BRIEF.md
# Lane Arrival Skew and Release Window Calculator

In a receiver with several serial lanes, each lane reaches its frame boundary at a slightly different moment. This block timestamps those moments. Each lane has its own free-running reference counter. The counter advances by one for every quad-byte strobe on that lane, wraps modulo 64, and is cleared by SYSREF. When a lane is enabled for capture, its first boundary pulse latches the lane's current count into an arrival register.

When every enabled lane holds a timestamp, the block places the stamps on a 64-position circle. It finds the arrival that starts the shortest arc covering all stamps; that arrival is the earliest lane, and the end of the arc is the latest lane. From these it reports the span of usable receive-buffer release delays and a suggested value near the middle of that span. An error flag shows when the measured skew leaves no usable value. The buffer depth that bounds the window is 16 quad-bytes, or 8 when the reduced-buffer mode is selected.

Top module: `lane_skew_window`

## Requirements
- R1: Each lane's reference counter advances by one, modulo 64, on every cycle its quad-byte strobe is high. SYSREF sets it to 0. A lane with no strobe keeps its count.
- R2: While a lane's capture enable is high, the lane's first boundary pulse latches that cycle's count (the value before any increment in that cycle) into its arrival output. Later pulses leave the value unchanged.
- R3: SYSREF clears all arrival values to 0, discards every capture and drops `valid_o` in the next cycle. Lowering and then raising a lane's enable re-arms that lane, so its next boundary pulse captures again. While the lane is disabled, its arrival value is held.
- R4: `valid_o` rises one cycle after the last enabled lane captures. Lanes that are not enabled are ignored. Out of reset, and whenever `valid_o` is low, all window outputs and `err_o` read 0.
- R5: The earliest lane is the enabled stamp from which the forward modular distance to every other enabled stamp is smallest. The latest lane is the earliest stamp plus that distance, so the result is correct when the stamps wrap past 63.
- R6: `rbd_min_o` = (latest stamp + 1) mod 64.
- R7: `rbd_max_o` = (earliest stamp + depth) mod 64, where depth is 16 when `half_buf_i` = 0 and 8 when `half_buf_i` = 1.
- R8: `mid_o` = (`rbd_min_o` + floor(((`rbd_max_o` − `rbd_min_o`) mod 64) / 2)) mod 64.
- R9: `err_o` is 1 while valid exactly when (latest − earliest) mod 64 ≥ depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sysref_i | input | 1 | Clears counters and captures |
| qb_stb_i | input | NUM_LANES | Per-lane quad-byte strobe |
| bnd_i | input | NUM_LANES | Per-lane frame boundary pulse |
| cap_en_i | input | NUM_LANES | Per-lane capture enable |
| half_buf_i | input | 1 | 1 selects the 8-deep buffer |
| arr_o | output | NUM_LANES*6 | Arrival stamps, lane l at bits [6l+5:6l] |
| rbd_min_o | output | 6 | Earliest usable release value |
| rbd_max_o | output | 6 | Latest usable release value |
| mid_o | output | 6 | Suggested release value |
| valid_o | output | 1 | Window outputs valid |
| err_o | output | 1 | Skew too large for the buffer |

## Verification
The hardest case to reach from the ports is a set of stamps that wraps past 63, so that the latest lane carries a smaller raw stamp than the earliest. The stimulus holds the strobes high after SYSREF and issues boundary pulses at absolute cycle offsets beyond 63. The counter therefore wraps between captures, and the expected window is derived from the unwrapped offsets. A second hard case is a count that differs between lanes. It is produced by gating one lane's strobe for more than a full counter period.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
   localparam int unsigned STAMP_W = 6;
   typedef logic [STAMP_W-1:0] stamp_t;
   typedef struct packed {
      stamp_t rmin;
      stamp_t rmax;
      stamp_t mid;
      logic   err;
   } win_t;
endpackage

// File: rtl/lsw_lane_stamp.sv
module lsw_lane_stamp
   import lsw_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sysref_i,
   input  logic   stb_i,
   input  logic   bnd_i,
   input  logic   en_i,
   output stamp_t arr_o,
   output logic   cap_o
);
   stamp_t cnt_q;
   stamp_t arr_q;
   logic   cap_q;
   logic   take;

   assign take = en_i && bnd_i && !cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sysref_i) begin
         cnt_q <= '0;
      end else if (stb_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= 1'b0;
         arr_q <= '0;
      end else if (sysref_i) begin
         cap_q <= 1'b0;
         arr_q <= '0;
      end else begin
         if (!en_i)     cap_q <= 1'b0;
         else if (take) cap_q <= 1'b1;
         if (take)      arr_q <= cnt_q;
      end
   end

   assign arr_o = arr_q;
   assign cap_o = cap_q;
endmodule

// File: rtl/lsw_arc_search.sv
module lsw_arc_search
   import lsw_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4
) (
   input  stamp_t [NUM_LANES-1:0] stamp_i,
   input  logic   [NUM_LANES-1:0] en_i,
   output stamp_t                 early_o,
   output stamp_t                 span_o
);
   stamp_t span_a [NUM_LANES];

   for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_ref
      always_comb begin
         stamp_t d;
         span_a[gi] = '0;
         for (int j = 0; j < NUM_LANES; j++) begin
            d = stamp_i[j] - stamp_i[gi];
            if (en_i[j] && d > span_a[gi]) span_a[gi] = d;
         end
      end
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      early_o = '0;
      span_o  = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (en_i[i] && (!found || span_a[i] < span_o)) begin
            found   = 1'b1;
            early_o = stamp_i[i];
            span_o  = span_a[i];
         end
      end
   end
endmodule

// File: rtl/lsw_window_calc.sv
module lsw_window_calc
   import lsw_pkg::*;
#(
   parameter int unsigned DEPTH_FULL   = 16,
   parameter int unsigned DEPTH_HALF   = 8,
   parameter bit          HALF_MODE_EN = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sysref_i,
   input  logic   all_cap_i,
   input  logic   half_i,
   input  stamp_t early_i,
   input  stamp_t span_i,
   output win_t   win_o,
   output logic   valid_o
);
   localparam stamp_t DF = stamp_t'(DEPTH_FULL);
   localparam stamp_t DH = stamp_t'(DEPTH_HALF);

   stamp_t depth;
   win_t   nxt, win_q;
   logic   valid_q;

   if (HALF_MODE_EN) begin : g_mode
      assign depth = half_i ? DH : DF;
   end else begin : g_fixed
      assign depth = DF;
   end

   always_comb begin
      stamp_t w;
      nxt.rmin = early_i + span_i + 1'b1;
      nxt.rmax = early_i + depth;
      w        = nxt.rmax - nxt.rmin;
      nxt.mid  = nxt.rmin + (w >> 1);
      nxt.err  = (span_i >= depth);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         win_q   <= '0;
      end else if (sysref_i || !all_cap_i) begin
         valid_q <= 1'b0;
         win_q   <= '0;
      end else begin
         valid_q <= 1'b1;
         win_q   <= nxt;
      end
   end

   assign win_o   = win_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/lane_skew_window.sv
module lane_skew_window
   import lsw_pkg::*;
#(
   parameter int unsigned NUM_LANES    = 4,
   parameter int unsigned DEPTH_FULL   = 16,
   parameter int unsigned DEPTH_HALF   = 8,
   parameter bit          HALF_MODE_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sysref_i,
   input  logic [NUM_LANES-1:0]         qb_stb_i,
   input  logic [NUM_LANES-1:0]         bnd_i,
   input  logic [NUM_LANES-1:0]         cap_en_i,
   input  logic                         half_buf_i,
   output logic [NUM_LANES*STAMP_W-1:0] arr_o,
   output logic [STAMP_W-1:0]           rbd_min_o,
   output logic [STAMP_W-1:0]           rbd_max_o,
   output logic [STAMP_W-1:0]           mid_o,
   output logic                         valid_o,
   output logic                         err_o
);
   localparam int unsigned HALF_CIRCLE = (1 << STAMP_W) / 2;

   if (NUM_LANES < 1) begin : g_chk_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (DEPTH_FULL > HALF_CIRCLE || DEPTH_FULL == 0) begin : g_chk_full
      $error("DEPTH_FULL must lie in 1..half the stamp circle");
   end
   if (HALF_MODE_EN && (DEPTH_HALF >= DEPTH_FULL || DEPTH_HALF == 0)) begin : g_chk_half
      $error("DEPTH_HALF must be nonzero and below DEPTH_FULL");
   end

   stamp_t [NUM_LANES-1:0] stamp;
   logic   [NUM_LANES-1:0] cap_q;
   logic                   all_cap;
   stamp_t                 early_w, span_w;
   win_t                   win;

   for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      lsw_lane_stamp u_stamp (
         .clk      (clk),
         .rst_n    (rst_n),
         .sysref_i (sysref_i),
         .stb_i    (qb_stb_i[gl]),
         .bnd_i    (bnd_i[gl]),
         .en_i     (cap_en_i[gl]),
         .arr_o    (stamp[gl]),
         .cap_o    (cap_q[gl])
      );
      assign arr_o[gl*STAMP_W +: STAMP_W] = stamp[gl];
   end

   assign all_cap = (|cap_en_i) && ((cap_q & cap_en_i) == cap_en_i);

   lsw_arc_search #(.NUM_LANES(NUM_LANES)) u_arc (
      .stamp_i (stamp),
      .en_i    (cap_en_i),
      .early_o (early_w),
      .span_o  (span_w)
   );

   lsw_window_calc #(
      .DEPTH_FULL   (DEPTH_FULL),
      .DEPTH_HALF   (DEPTH_HALF),
      .HALF_MODE_EN (HALF_MODE_EN)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .sysref_i  (sysref_i),
      .all_cap_i (all_cap),
      .half_i    (half_buf_i),
      .early_i   (early_w),
      .span_i    (span_w),
      .win_o     (win),
      .valid_o   (valid_o)
   );

   assign rbd_min_o = win.rmin;
   assign rbd_max_o = win.rmax;
   assign mid_o     = win.mid;
   assign err_o     = win.err;
endmodule

// File: rtl/lane_skew_window_chk.sv
module lane_skew_window_chk #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned W         = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sysref_i,
   input logic                   half_buf_i,
   input logic [NUM_LANES*W-1:0] arr_o,
   input logic [W-1:0]           rbd_min_o,
   input logic [W-1:0]           rbd_max_o,
   input logic [W-1:0]           mid_o,
   input logic                   valid_o,
   input logic                   err_o,
   input logic [NUM_LANES-1:0]   cap_q,
   input logic                   all_cap,
   input logic [W-1:0]           early_w,
   input logic [W-1:0]           span_w
);
   assert_rise_after_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(all_cap));

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (rbd_min_o == '0 && rbd_max_o == '0 && mid_o == '0 && !err_o));

   assert_sysref_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sysref_i |=> (!valid_o && arr_o == '0));

   assert_min_after_latest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(sysref_i)) |-> rbd_min_o == W'($past(early_w) + $past(span_w) + 1'b1));

   assert_width_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !err_o) |-> (W'(rbd_max_o - rbd_min_o) < (half_buf_i ? W'(8) : W'(16))
                               || $changed(half_buf_i)));

   assert_mid_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (W'(mid_o - rbd_min_o) <= W'(rbd_max_o - rbd_min_o)));

   for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_hold
      assert_stamp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q[gl] && !sysref_i) |=> $stable(arr_o[gl*W +: W]));
   end
endmodule

bind lane_skew_window lane_skew_window_chk #(.NUM_LANES(NUM_LANES), .W(lsw_pkg::STAMP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sysref_i   (sysref_i),
   .half_buf_i (half_buf_i),
   .arr_o      (arr_o),
   .rbd_min_o  (rbd_min_o),
   .rbd_max_o  (rbd_max_o),
   .mid_o      (mid_o),
   .valid_o    (valid_o),
   .err_o      (err_o),
   .cap_q      (cap_q),
   .all_cap    (all_cap),
   .early_w    (early_w),
   .span_w     (span_w)
);

// File: tb/lane_skew_window_bench.sv
module lane_skew_window_bench;
   localparam int NL = 4;

   typedef struct {
      int    mn;
      int    mx;
      int    md;
      bit    e;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sysref = 1'b0;
   logic [NL-1:0] stb = '0;
   logic [NL-1:0] bnd = '0;
   logic [NL-1:0] en = '0;
   logic          half = 1'b0;
   logic [NL*6-1:0] arr;
   logic [5:0]    rmin, rmax, mid;
   logic          valid, err;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   bit   prev_v = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   lane_skew_window u_lane_skew_window (
      .clk(clk), .rst_n(rst_n), .sysref_i(sysref), .qb_stb_i(stb), .bnd_i(bnd),
      .cap_en_i(en), .half_buf_i(half), .arr_o(arr), .rbd_min_o(rmin),
      .rbd_max_o(rmax), .mid_o(mid), .valid_o(valid), .err_o(err));

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int lane_arr(input int l);
      return int'(arr[l*6 +: 6]);
   endfunction

   // monitor: pops one expected window each time valid rises
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (valid && !prev_v) begin
            if (q.size() == 0) begin
               check(1'b0, "R4 unexpected valid", 1, 0);
            end else begin
               exp_t x;
               x = q.pop_front();
               check(int'(rmin) == x.mn, {"R6 rbd_min ", x.tag}, rmin, x.mn);
               check(int'(rmax) == x.mx, {"R7 rbd_max ", x.tag}, rmax, x.mx);
               check(int'(mid) == x.md, {"R8 mid ", x.tag}, mid, x.md);
               check(err == x.e, {"R9 err ", x.tag}, err, x.e);
            end
         end
         prev_v = valid;
      end
   end

   task automatic push_exp(input int mn, input int mx, input int md, input bit e, input string tag);
      exp_t x;
      x.mn = mn; x.mx = mx; x.md = md; x.e = e; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic drain();
      wait (q.size() == 0);
      repeat (2) @(negedge clk);
   endtask

   // R5: expected window from unwrapped arrival offsets
   task automatic run_case(input int a[NL], input bit hb, input logic [NL-1:0] m, input string tag);
      int lo, hi, depth, mn, mx, w, top;
      lo = 1000; hi = -1; top = 0;
      for (int l = 0; l < NL; l++) begin
         if (a[l] > top) top = a[l];
         if (m[l]) begin
            if (a[l] < lo) lo = a[l];
            if (a[l] > hi) hi = a[l];
         end
      end
      depth = hb ? 8 : 16;
      mn = (hi + 1) % 64;
      mx = (lo + depth) % 64;
      w  = (mx - mn + 64) % 64;
      push_exp(mn, mx, (mn + w / 2) % 64, (hi - lo) >= depth, tag);
      @(negedge clk);
      sysref = 1'b1; stb = '1; bnd = '0; en = m; half = hb;
      @(negedge clk);
      sysref = 1'b0;
      for (int c = 0; c <= top; c++) begin
         for (int l = 0; l < NL; l++) bnd[l] = (a[l] == c);
         @(negedge clk);
      end
      bnd = '0;
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(valid == 1'b0 && rmin == 0 && rmax == 0 && mid == 0 && err == 1'b0,
            "R4 reset state", valid, 0);
      check(arr == '0, "R3 reset arrivals", int'(arr[5:0]), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_case('{3, 7, 5, 10}, 1'b0, 4'b1111, "plain");
      for (int l = 0; l < NL; l++)
         check(lane_arr(l) == (l == 0 ? 3 : l == 1 ? 7 : l == 2 ? 5 : 10), "R2 stamp", lane_arr(l), l);
      // R2: repeat pulses ignored
      bnd = 4'b0001;
      @(negedge clk);
      bnd = '0;
      repeat (2) @(negedge clk);
      check(lane_arr(0) == 3, "R2 second pulse ignored", lane_arr(0), 3);
      check(valid == 1'b1 && rmin == 11, "R2 window unchanged", rmin, 11);

      // R3: SYSREF clears
      sysref = 1'b1;
      @(negedge clk);
      sysref = 1'b0;
      @(negedge clk);
      check(arr == '0, "R3 sysref clears stamps", int'(arr[11:6]), 0);
      check(valid == 1'b0, "R3 sysref drops valid", valid, 0);

      run_case('{60, 66, 62, 64}, 1'b0, 4'b1111, "R5 wrap");
      run_case('{20, 24, 22, 21}, 1'b1, 4'b1111, "R7 half depth");
      run_case('{10, 18, 12, 11}, 1'b1, 4'b1111, "R9 half overflow");
      run_case('{0, 16, 5, 5}, 1'b0, 4'b1111, "R9 full overflow");
      run_case('{40, 42, 41, 45}, 1'b0, 4'b0111, "R4 lane3 disabled");
      check(lane_arr(3) == 0, "R4 disabled lane not captured", lane_arr(3), 0);
      run_case('{63, 63, 63, 63}, 1'b0, 4'b1111, "R6 equal at 63");

      // R1: gated strobe, lane0 counts 70 -> 6, lane1 stays 0
      push_exp(7, 16, 11, 1'b0, "R1 gated");
      @(negedge clk);
      sysref = 1'b1; stb = 4'b0001; en = 4'b0011; half = 1'b0; bnd = '0;
      @(negedge clk);
      sysref = 1'b0;
      repeat (70) @(negedge clk);
      bnd = 4'b0011; stb = '0;
      @(negedge clk);
      bnd = '0;
      drain();
      check(lane_arr(0) == 6, "R1 wrapped count", lane_arr(0), 6);
      check(lane_arr(1) == 0, "R1 idle lane count", lane_arr(1), 0);

      // R3: re-arm lane0
      en = 4'b0010;
      repeat (2) @(negedge clk);
      check(lane_arr(0) == 6, "R3 held while disabled", lane_arr(0), 6);
      push_exp(10, 16, 13, 1'b0, "R3 rearm");
      en = 4'b0011; stb = 4'b0001;
      repeat (3) @(negedge clk);
      stb = '0;
      check(valid == 1'b0, "R3 rearm drops valid", valid, 0);
      bnd = 4'b0001;
      @(negedge clk);
      bnd = '0;
      drain();
      check(lane_arr(0) == 9, "R3 recapture", lane_arr(0), 9);
      check(q.size() == 0, "R4 all windows seen", q.size(), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog R4 actual=%0d expected=%0d", q.size(), 0);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule